// File: doc/BRIEF.md
# Nonce-to-initial-offset unit for offset-codebook encryption

This block turns a message nonce into the starting offset that an offset-codebook authenticated-encryption datapath needs before it can process the first message block. The nonce is placed in a 128-bit word: zero fill at the top, a single marker 1 bit, then the nonce. The six low bits of that word are cleared to form the block-cipher input. The six low nonce bits, called the bottom, are kept aside. The unit sends the cleared word to an external block-cipher core through a request/response handshake. When the result returns, the unit widens it to a 192-bit stretch value. A 6-bit barrel shift by the bottom then selects the 128-bit offset.

The latest cipher result is cached together with the input that produced it. Nonces that come from a counter share a cipher input across each run of 64 consecutive values, so 63 of every 64 such nonces skip the cipher call. A key change invalidates the cache. While a cipher result is pending, the unit refuses new nonces by holding its ready output low.

Top module: `ocb_nonce_offset`

## Requirements
- R1: After reset, `nonce_ready_o` is 1, and `offset_valid_o` and `enc_req_o` are 0.
- R2: A cipher request carries a 128-bit word built as follows: bits above position NONCE_W are 0, bit NONCE_W is 1, bits NONCE_W-1 down to 6 hold the same nonce bits, and bits 5 to 0 are 0.
- R3: With K the cipher result, the stretch is the 192-bit value {K, K[127:64] XOR K[119:56]}. The offset is bits 191 down to 64 of the stretch shifted left by the bottom (nonce bits 5 to 0).
- R4: The bottom and the nonce are captured when a nonce is accepted. Changes on `nonce_i` after that point do not affect the offset that results.
- R5: If the cache holds a valid result for the same cipher input, no cipher request is made. `offset_valid_o` is then high in the cycle right after the accepting edge.
- R6: A nonce that misses the cache causes exactly one cipher request, which `enc_req_o` signals as a one-cycle pulse. A sweep of 128 consecutive counter nonces that starts on a multiple of 64 therefore makes exactly two requests.
- R7: `nonce_ready_o` is low from the accepting edge until the cycle in which `offset_valid_o` is high. A `nonce_valid_i` pulse while ready is low produces no output and no request.
- R8: A `key_chg_i` pulse invalidates the cache. This applies even when the pulse arrives while a request is pending: the returning result is then not cached, and the next nonce with the same upper bits causes a new request.
- R9: `offset_valid_o` is a one-cycle pulse, and `offset_o` holds its value in every cycle in which `offset_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_chg_i | input | 1 | One-cycle pulse when the cipher key changes |
| nonce_valid_i | input | 1 | Nonce offered |
| nonce_ready_o | output | 1 | Unit can accept a nonce |
| nonce_i | input | NONCE_W | Nonce value |
| enc_req_o | output | 1 | One-cycle cipher request pulse |
| enc_data_o | output | BLK_W | Cipher input word |
| enc_ack_i | input | 1 | Cipher result valid |
| enc_rsp_i | input | BLK_W | Cipher result |
| offset_valid_o | output | 1 | One-cycle pulse: offset ready |
| offset_o | output | BLK_W | Initial offset |

## Verification
The bench builds the unit with NONCE_W = 20 and the default BLK_W = 128. With that width the marker bit sits at a position the bench can inspect directly, and a counter sweep crosses 64-nonce group boundaries within a few hundred cycles. The cipher stand-in is a keyed mixing function whose response latency the bench varies from one to four cycles. The longer latencies make room for a key change and a refused nonce to land while a request is pending. The bottom values 0 and 63 test both ends of the barrel shifter.

// File: rtl/ocb_nonce_pkg.sv
package ocb_nonce_pkg;
  localparam int OFS_BOT_W  = 6;
  localparam int OFS_MIX_SH = 8;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_EMIT} ofs_state_e;
endpackage

// File: rtl/ocb_nonce_format.sv
module ocb_nonce_format #(
  parameter int NONCE_W = 96,
  parameter int BLK_W   = 128,
  parameter int BOT_W   = 6
) (
  input  logic [NONCE_W-1:0] nonce,
  output logic [BLK_W-1:0]   masked,
  output logic [BOT_W-1:0]   bottom
);
  always_comb begin
    masked                 = '0;
    masked[NONCE_W-1:0]    = nonce;
    masked[NONCE_W]        = 1'b1;
    masked[BOT_W-1:0]      = '0;
    bottom                 = nonce[BOT_W-1:0];
  end
endmodule

// File: rtl/ocb_stretch_shift.sv
module ocb_stretch_shift #(
  parameter int BLK_W  = 128,
  parameter int BOT_W  = 6,
  parameter int MIX_SH = 8
) (
  input  logic [BLK_W-1:0] ktop,
  input  logic [BOT_W-1:0] bottom,
  output logic [BLK_W-1:0] offset
);
  localparam int HALF  = BLK_W / 2;
  localparam int STR_W = BLK_W + HALF;

  logic [STR_W-1:0] stretch;
  logic [STR_W-1:0] acc;

  assign stretch = {ktop, ktop[BLK_W-1 -: HALF] ^ ktop[BLK_W-1-MIX_SH -: HALF]};

  // logarithmic shifter: one conditional stage per bottom bit
  always_comb begin
    acc = stretch;
    for (int k = 0; k < BOT_W; k++) begin
      if (bottom[k]) acc = acc << (1 << k);
    end
  end

  assign offset = acc[STR_W-1 -: BLK_W];
endmodule

// File: rtl/ocb_nonce_offset.sv
module ocb_nonce_offset
  import ocb_nonce_pkg::*;
#(
  parameter int NONCE_W = 96,
  parameter int BLK_W   = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               key_chg_i,
  input  logic               nonce_valid_i,
  output logic               nonce_ready_o,
  input  logic [NONCE_W-1:0] nonce_i,
  output logic               enc_req_o,
  output logic [BLK_W-1:0]   enc_data_o,
  input  logic               enc_ack_i,
  input  logic [BLK_W-1:0]   enc_rsp_i,
  output logic               offset_valid_o,
  output logic [BLK_W-1:0]   offset_o
);
  localparam int BOT_W = OFS_BOT_W;

  ofs_state_e       state;
  logic [BOT_W-1:0] bot_q;
  logic [BLK_W-1:0] cache_key;
  logic [BLK_W-1:0] cache_dat;
  logic             cache_vld;
  logic             stale_q;

  logic [BLK_W-1:0] fmt_masked;
  logic [BOT_W-1:0] fmt_bot;
  logic [BLK_W-1:0] shift_out;
  logic             accept;
  logic             hit;

  ocb_nonce_format #(.NONCE_W(NONCE_W), .BLK_W(BLK_W), .BOT_W(BOT_W)) fmt_i (
    .nonce  (nonce_i),
    .masked (fmt_masked),
    .bottom (fmt_bot)
  );

  ocb_stretch_shift #(.BLK_W(BLK_W), .BOT_W(BOT_W), .MIX_SH(OFS_MIX_SH)) shf_i (
    .ktop   (cache_dat),
    .bottom (bot_q),
    .offset (shift_out)
  );

  assign nonce_ready_o = (state == ST_IDLE);
  assign accept        = nonce_valid_i && nonce_ready_o;
  assign hit           = cache_vld && !key_chg_i && (fmt_masked == cache_key);

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      bot_q          <= '0;
      cache_key      <= '0;
      cache_dat      <= '0;
      cache_vld      <= 1'b0;
      stale_q        <= 1'b0;
      enc_req_o      <= 1'b0;
      enc_data_o     <= '0;
      offset_valid_o <= 1'b0;
      offset_o       <= '0;
    end else begin
      enc_req_o      <= 1'b0;
      offset_valid_o <= 1'b0;
      if (key_chg_i) cache_vld <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            bot_q <= fmt_bot;
            if (hit) begin
              state <= ST_EMIT;
            end else begin
              cache_key  <= fmt_masked;
              cache_vld  <= 1'b0;
              stale_q    <= 1'b0;
              enc_req_o  <= 1'b1;
              enc_data_o <= fmt_masked;
              state      <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (key_chg_i) stale_q <= 1'b1;
          if (enc_ack_i) begin
            cache_dat <= enc_rsp_i;
            cache_vld <= !(stale_q || key_chg_i);
            state     <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          offset_o       <= shift_out;
          offset_valid_o <= 1'b1;
          state          <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ocb_nonce_offset_chk.sv
module ocb_nonce_offset_chk #(
  parameter int NONCE_W = 96,
  parameter int BLK_W   = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             nonce_ready_o,
  input logic             enc_req_o,
  input logic [BLK_W-1:0] enc_data_o,
  input logic             offset_valid_o,
  input logic [BLK_W-1:0] offset_o
);
  assert_req_word_R2: assert property (@(posedge clk) disable iff (rst)
    enc_req_o |-> (enc_data_o[5:0] == 6'd0 && enc_data_o[NONCE_W] == 1'b1 &&
                   (enc_data_o >> (NONCE_W + 1)) == '0));

  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    enc_req_o |=> !enc_req_o);

  assert_busy_while_req_R7: assert property (@(posedge clk) disable iff (rst)
    enc_req_o |-> !nonce_ready_o);

  assert_ready_returns_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(nonce_ready_o) |-> offset_valid_o);

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    offset_valid_o |=> !offset_valid_o);

  assert_offset_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !offset_valid_o |=> (offset_valid_o || $stable(offset_o)));
endmodule

bind ocb_nonce_offset ocb_nonce_offset_chk #(.NONCE_W(NONCE_W), .BLK_W(BLK_W)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .nonce_ready_o  (nonce_ready_o),
  .enc_req_o      (enc_req_o),
  .enc_data_o     (enc_data_o),
  .offset_valid_o (offset_valid_o),
  .offset_o       (offset_o)
);

// File: tb/ocb_nonce_offset_tb.sv
module ocb_nonce_offset_tb_top;
  localparam int NW = 20;

  typedef struct {
    logic [127:0] ofs;
    bit           hit;
    int           acc;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          key_chg_i = 1'b0;
  logic          nonce_valid_i = 1'b0;
  logic          nonce_ready_o;
  logic [NW-1:0] nonce_i = '0;
  logic          enc_req_o;
  logic [127:0]  enc_data_o;
  logic          enc_ack_i = 1'b0;
  logic [127:0]  enc_rsp_i = '0;
  logic          offset_valid_o;
  logic [127:0]  offset_o;

  int checks = 0, fails = 0, cyc = 0, lat = 2;
  int req_seen = 0, exp_req = 0, key_id = 0, ciph_key = 0;
  bit m_vld = 0;
  logic [127:0] m_key = '0, m_dat = '0, exp_fmt = '0, last_ofs = '0;
  bit prev_v = 0;
  exp_t exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ocb_nonce_offset #(.NONCE_W(NW), .BLK_W(128)) dut_i (
    .clk(clk), .rst(rst), .key_chg_i(key_chg_i),
    .nonce_valid_i(nonce_valid_i), .nonce_ready_o(nonce_ready_o), .nonce_i(nonce_i),
    .enc_req_o(enc_req_o), .enc_data_o(enc_data_o),
    .enc_ack_i(enc_ack_i), .enc_rsp_i(enc_rsp_i),
    .offset_valid_o(offset_valid_o), .offset_o(offset_o)
  );

  function automatic logic [127:0] fmt_ref(input logic [NW-1:0] n);
    logic [127:0] f;
    f = 128'(n);
    f[NW] = 1'b1;
    f[5:0] = 6'd0;
    return f;
  endfunction

  function automatic logic [127:0] ciph(input logic [127:0] x, input int k);
    logic [63:0] kk;
    kk = 64'h9E3779B97F4A7C15 * 64'(k + 1);
    return {x[63:0] ^ kk, x[127:64] ^ {x[31:0], x[63:32]} ^ 64'hC2B2AE3D27D4EB4F};
  endfunction

  function automatic logic [127:0] ofs_ref(input logic [127:0] k, input logic [5:0] b);
    logic [191:0] s;
    s = {k, k[127:64] ^ k[119:56]};
    s = s << b;
    return s[191:64];
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [NW-1:0] n, input bit poke, input bit kchg);
    logic [127:0] f;
    exp_t e;
    f = fmt_ref(n);
    e.hit = m_vld && (f == m_key);
    if (!e.hit) begin
      exp_req++;
      m_key = f;
      m_dat = ciph(f, key_id);
      m_vld = 1;
    end
    if (kchg) m_vld = 0;
    e.ofs = ofs_ref(m_dat, n[5:0]);
    exp_fmt = f;
    ciph_key = key_id;
    @(negedge clk);
    while (!nonce_ready_o) @(negedge clk);
    nonce_i = n;
    nonce_valid_i = 1'b1;
    @(negedge clk);
    nonce_valid_i = 1'b0;
    nonce_i = ~n;                       // R4: input scrambled after acceptance
    e.acc = cyc;
    exp_q.push_back(e);
    if (kchg) begin
      key_chg_i = 1'b1;
      key_id++;
      @(negedge clk);
      key_chg_i = 1'b0;
    end
    if (poke) begin                     // R7: offer while busy
      nonce_i = n ^ 20'h00440;
      nonce_valid_i = 1'b1;
      @(negedge clk);
      nonce_valid_i = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic key_change_idle();
    @(negedge clk);
    key_chg_i = 1'b1;
    key_id++;
    m_vld = 0;
    @(negedge clk);
    key_chg_i = 1'b0;
  endtask

  task automatic check_req(input string req);
    @(negedge clk);
    check(req_seen == exp_req, req, 128'(req_seen), 128'(exp_req));
  endtask

  // cipher stand-in
  initial begin : cipher_model
    logic [127:0] d;
    forever begin
      @(negedge clk);
      if (enc_req_o) begin
        d = enc_data_o;
        req_seen++;
        check(d === exp_fmt, "R2 request word", d, exp_fmt);
        repeat (lat) @(negedge clk);
        enc_ack_i = 1'b1;
        enc_rsp_i = ciph(d, ciph_key);
        @(negedge clk);
        enc_ack_i = 1'b0;
        enc_rsp_i = '0;
      end
    end
  end

  // scoreboard monitor
  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (offset_valid_o) begin
          if (exp_q.size() == 0) begin
            check(0, "R7 unexpected offset", offset_o, '0);
          end else begin
            e = exp_q.pop_front();
            check(offset_o === e.ofs, "R3 offset", offset_o, e.ofs);
            if (e.hit) check(cyc == e.acc + 1, "R5 hit latency", 128'(cyc), 128'(e.acc + 1));
          end
          check(!prev_v, "R9 single-cycle valid", 128'(prev_v), 128'(0));
          last_ofs = offset_o;
        end else if (offset_o !== last_ofs) begin
          check(0, "R9 offset hold", offset_o, last_ofs);
        end
        prev_v = offset_valid_o;
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(nonce_ready_o === 1'b1, "R1 ready after reset", 128'(nonce_ready_o), 128'(1));
    check(offset_valid_o === 1'b0, "R1 valid after reset", 128'(offset_valid_o), 128'(0));
    check(enc_req_o === 1'b0, "R1 request after reset", 128'(enc_req_o), 128'(0));

    // R6: first nonce is a miss
    lat = 3;
    send(20'h00040, 0, 0);
    check_req("R6 single request on miss");

    // R5 / R6: counter sweep of 128 nonces from a multiple of 64
    base = req_seen;
    for (int i = 'h40; i < 'hC0; i++) send(NW'(i), 0, 0);
    check_req("R5 cached hits skip cipher");
    check(req_seen == base + 1, "R6 two requests across sweep", 128'(req_seen - base + 1), 128'(2));

    // R7 / R4: refused nonce while pending, scrambled input after accept
    lat = 4;
    send(20'h12345, 1, 0);
    check_req("R7 refused nonce makes no request");
    send(20'h12346, 1, 0);
    check_req("R7 refused nonce during hit");

    // R8: key change while pending, result not cached
    lat = 3;
    send(20'h5A5C0, 0, 1);
    send(20'h5A5C1, 0, 0);
    check_req("R8 pending key change forces new request");

    // R8: key change while idle
    send(20'h5A5C2, 0, 0);
    key_change_idle();
    send(20'h5A5C3, 0, 0);
    check_req("R8 idle key change forces new request");

    // R3: shifter extremes
    lat = 1;
    send(20'hFFFFF, 0, 0);
    send(20'hFFFC0, 0, 0);
    send(20'h00001, 0, 0);
    send(20'hABCDE, 0, 0);
    check_req("R3 extremes request count");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule